// File: doc/BRIEF.md
# Serial port status flag register

This block keeps the four event-driven status flags of a serial port and applies their set and clear rules. The transmitter reports when its holding register has moved into the shift register and when a frame carrying data has finished. The line monitor reports a detected LIN break. The clear-to-send pin is sampled directly. The receive-side flags (receive-not-empty, idle, overrun, noise, framing, parity) are owned elsewhere and appear here only as a six-bit input that is mirrored into the readback.

Software reads the 32-bit status word. It clears the break and clear-to-send flags by writing zeros to them. The transmit-empty flag clears as a side effect of a data register write. Transmit-complete clears in one of two ways. The first is a direct zero write. The second is a data write that follows a status read, which a two-state marker machine tracks: `MK_IDLE` moves to `MK_ARMED` on a status read, and `MK_ARMED` returns to `MK_IDLE` on a data write that has no status read in the same cycle. A registered interrupt request combines the four flags with their enables.

Top module: `ser_stat_flags`

## Requirements
- R1: After reset the status word reads 0x0000_00C0 (transmit-empty bit 7 and transmit-complete bit 6 set, receive inputs at zero), and the interrupt output is low while all enables are low.
- R2: Status bits 31..10 always read 0, and a status write with ones in those bits does not change the readback.
- R3: Status bits 5..0 equal the `rx_flags` input in the same cycle, and status writes do not alter them.
- R4: Transmit-empty (bit 7) is 1 in the cycle after a `evt_txe_load` strobe. It is 0 in the cycle after a `wr_data` strobe unless `evt_txe_load` arrives in the same cycle, in which case setting wins. A status write with bit 7 at 0 leaves it unchanged.
- R5: Transmit-complete (bit 6) becomes 1 in the cycle after `evt_frame_done` only if transmit-empty is already 1 in that cycle. Otherwise the strobe is ignored.
- R6: A status write with bit 6 at 0 clears transmit-complete in the next cycle. A status write with bit 6 at 1 leaves it unchanged.
- R7: A `wr_data` strobe clears transmit-complete only while the marker is in `MK_ARMED`, that is, when a status read happened in an earlier cycle and no data write has occurred since. A status read in the same cycle as the data write does not count for that write, but it leaves the marker armed.
- R8: The break flag (bit 8) is 1 in the cycle after `evt_brk`. A status write with bit 8 at 0 clears it, and a write with bit 8 at 1 leaves it unchanged. If a set and a clear arrive in the same cycle, setting wins.
- R9: While `cts_flow_en` is 1, a level change on `cts_n_in` sets the clear-to-send flag (bit 9) on the third rising edge after the change. While `cts_flow_en` is 0, changes are ignored. A status write with bit 9 at 0 clears the flag.
- R10: `irq` is 1 in the cycle after any of these pairs is true together: (bit 9, `ie_cts`), (bit 8, `ie_brk`), (bit 7, `ie_txe`), (bit 6, `ie_tc`). It is 0 in the cycle after none of them is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| evt_txe_load | input | 1 | Strobe: holding register moved into the shifter |
| evt_frame_done | input | 1 | Strobe: a data frame finished transmitting |
| evt_brk | input | 1 | Strobe: break condition detected |
| cts_n_in | input | 1 | Asynchronous clear-to-send pin level |
| cts_flow_en | input | 1 | Enables clear-to-send change detection |
| rd_stat | input | 1 | Bus read strobe of the status word |
| wr_stat | input | 1 | Bus write strobe of the status word |
| wr_data | input | 1 | Bus write strobe of the data register |
| wdata | input | 32 | Bus write data |
| rx_flags | input | 6 | Receive-side flags, mirrored to bits 5..0 |
| ie_cts | input | 1 | Interrupt enable for bit 9 |
| ie_brk | input | 1 | Interrupt enable for bit 8 |
| ie_txe | input | 1 | Interrupt enable for bit 7 |
| ie_tc | input | 1 | Interrupt enable for bit 6 |
| stat_rdata | output | 32 | Status word readback |
| irq | output | 1 | Registered interrupt request |

## Verification
Each flag result is due on the first rising edge after its strobe, so the bench drives a strobe at a falling edge and compares the readback at the next falling edge. The interrupt is one register further on and is checked one falling edge after its flag. Clear-to-send passes through two synchronizer stages and one compare register, so the bench checks that the flag is still clear after two edges and set after the third. The receive mirror has no register and is checked a short delay after `rx_flags` changes.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
    localparam int STAT_W   = 32;
    localparam int RX_W     = 6;
    localparam int NFLAG    = 4;
    localparam int IDX_TC   = 0;
    localparam int IDX_TXE  = 1;
    localparam int IDX_LBK  = 2;
    localparam int IDX_CTS  = 3;
    localparam int BIT_TC   = RX_W + IDX_TC;
    localparam int BIT_TXE  = RX_W + IDX_TXE;
    localparam int BIT_LBK  = RX_W + IDX_LBK;
    localparam int BIT_CTS  = RX_W + IDX_CTS;
    localparam int TOP_W    = STAT_W - NFLAG - RX_W;
    localparam logic [NFLAG-1:0] FLAG_RST = 4'b0011;

    typedef enum logic {
        MK_IDLE  = 1'b0,
        MK_ARMED = 1'b1
    } mark_st_t;
endpackage

// File: rtl/ser_flag_cell.sv
module ser_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= RST_VAL;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8 / R4: a hardware set beats a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ser_clr_arm.sv
module ser_clr_arm
    import ser_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stat_i,
    input  logic wr_data_i,
    output logic armed_o
);
    mark_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= MK_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MK_IDLE: begin
                if (rd_stat_i)
                    st_d = MK_ARMED;
            end
            MK_ARMED: begin
                if (!rd_stat_i && wr_data_i)
                    st_d = MK_IDLE;
            end
            default: st_d = MK_IDLE;
        endcase
    end

    always_comb begin
        armed_o = (st_q == MK_ARMED);
    end

    a_r7_arms_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i |=> armed_o);

    a_r7_disarms_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_i && !rd_stat_i) |=> !armed_o);
endmodule

// File: rtl/ser_cts_mon.sv
module ser_cts_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_i,
    input  logic en_i,
    output logic toggle_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= cts_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    assign toggle_o = en_i && (sync_q[LAST] != prev_q);

    a_r9_no_toggle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !toggle_o);
endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags
    import ser_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_txe_load,
    input  logic              evt_frame_done,
    input  logic              evt_brk,
    input  logic              cts_n_in,
    input  logic              cts_flow_en,
    input  logic              rd_stat,
    input  logic              wr_stat,
    input  logic              wr_data,
    input  logic [STAT_W-1:0] wdata,
    input  logic [RX_W-1:0]   rx_flags,
    input  logic              ie_cts,
    input  logic              ie_brk,
    input  logic              ie_txe,
    input  logic              ie_tc,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq
);
    logic             armed;
    logic             cts_toggle;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flags_v;
    logic [NFLAG-1:0] ie_v;
    logic             irq_q;

    ser_clr_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stat_i (rd_stat),
        .wr_data_i (wr_data),
        .armed_o   (armed)
    );

    ser_cts_mon #(.SYNC_STAGES(2)) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_n_i  (cts_n_in),
        .en_i     (cts_flow_en),
        .toggle_o (cts_toggle)
    );

    always_comb begin
        set_v[IDX_TC]  = evt_frame_done && flags_v[IDX_TXE];
        set_v[IDX_TXE] = evt_txe_load;
        set_v[IDX_LBK] = evt_brk;
        set_v[IDX_CTS] = cts_toggle;

        clr_v[IDX_TC]  = (wr_stat && !wdata[BIT_TC]) || (wr_data && armed);
        clr_v[IDX_TXE] = wr_data;
        clr_v[IDX_LBK] = wr_stat && !wdata[BIT_LBK];
        clr_v[IDX_CTS] = wr_stat && !wdata[BIT_CTS];

        ie_v[IDX_TC]   = ie_tc;
        ie_v[IDX_TXE]  = ie_txe;
        ie_v[IDX_LBK]  = ie_brk;
        ie_v[IDX_CTS]  = ie_cts;
    end

    genvar i;
    generate
        for (i = 0; i < NFLAG; i++) begin : g_flag
            ser_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_v[i]),
                .clr_i  (clr_v[i]),
                .flag_o (flags_v[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_v & ie_v);
    end

    assign irq        = irq_q;
    assign stat_rdata = {{TOP_W{1'b0}}, flags_v, rx_flags};

    a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (wdata[STAT_W-1:RX_W+NFLAG] != '0)) |=> (stat_rdata[STAT_W-1:RX_W+NFLAG] == '0));

    a_r3_rx_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (wdata[RX_W-1:0] != rx_flags)) |-> (stat_rdata[RX_W-1:0] == rx_flags));

    a_r4_txe_ignores_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_v[IDX_TXE] && wr_stat && !wdata[BIT_TXE] && !wr_data) |=> flags_v[IDX_TXE]);

    a_r5_tc_needs_txe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_v[IDX_TC]) |-> $past(flags_v[IDX_TXE]));

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_flow_en && !flags_v[IDX_CTS]) |=> !flags_v[IDX_CTS]);

    a_r10_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_v[IDX_TXE] && ie_txe) |=> irq);

    a_r10_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_v & ie_v) == '0) |=> !irq);
endmodule

// File: tb/test_ser_stat_flags.sv
`timescale 1ns/1ps
module test_ser_stat_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_txe_load = 1'b0, evt_frame_done = 1'b0, evt_brk = 1'b0;
    logic        cts_n_in = 1'b1, cts_flow_en = 1'b0;
    logic        rd_stat = 1'b0, wr_stat = 1'b0, wr_data = 1'b0;
    logic [31:0] wdata = '0;
    logic [5:0]  rx_flags = '0;
    logic        ie_cts = 1'b0, ie_brk = 1'b0, ie_txe = 1'b0, ie_tc = 1'b0;
    logic [31:0] stat_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ser_stat_flags i_ser_stat_flags (
        .clk(clk), .rst_n(rst_n),
        .evt_txe_load(evt_txe_load), .evt_frame_done(evt_frame_done), .evt_brk(evt_brk),
        .cts_n_in(cts_n_in), .cts_flow_en(cts_flow_en),
        .rd_stat(rd_stat), .wr_stat(wr_stat), .wr_data(wr_data), .wdata(wdata),
        .rx_flags(rx_flags),
        .ie_cts(ie_cts), .ie_brk(ie_brk), .ie_txe(ie_txe), .ie_tc(ie_tc),
        .stat_rdata(stat_rdata), .irq(irq)
    );

    // vector: rd, ws, wd, txe_evt, done_evt, brk_evt, wdata[9:0], expected[9:0]
    function automatic logic [25:0] mk(input logic rd, ws, wd, tx, dn, bk,
                                       input logic [9:0] wd10, input logic [9:0] ex);
        return {rd, ws, wd, tx, dn, bk, wd10, ex};
    endfunction

    localparam int NV = 22;
    localparam logic [25:0] VEC [NV] = '{
        mk(0,0,1,0,0,0, 10'h000, 10'h040), // R4 data write clears TXE; R7 no read -> TC kept
        mk(0,1,0,0,0,0, 10'h000, 10'h000), // R6 zero write clears TC
        mk(0,0,0,1,0,0, 10'h000, 10'h080), // R4 load event sets TXE
        mk(0,1,0,0,0,0, 10'h000, 10'h080), // R4 status zero write ignored by TXE
        mk(0,0,0,0,1,0, 10'h000, 10'h0C0), // R5 frame done with TXE=1
        mk(0,0,1,0,0,0, 10'h000, 10'h040), // R7 write without read keeps TC
        mk(0,1,0,0,0,0, 10'h040, 10'h040), // R6 one in bit 6 keeps TC
        mk(1,0,0,0,0,0, 10'h000, 10'h040), // R7 status read arms
        mk(0,0,1,0,0,0, 10'h000, 10'h000), // R7 armed data write clears TC
        mk(0,0,0,0,1,0, 10'h000, 10'h000), // R5 frame done with TXE=0 ignored
        mk(0,0,0,0,0,1, 10'h000, 10'h100), // R8 break sets
        mk(0,1,0,0,0,0, 10'h100, 10'h100), // R8 one in bit 8 keeps
        mk(0,1,0,0,0,0, 10'h000, 10'h000), // R8 zero clears
        mk(0,1,0,0,0,1, 10'h000, 10'h100), // R8 set wins over clear
        mk(0,0,1,1,0,0, 10'h000, 10'h180), // R4 set wins over data write
        mk(0,1,0,0,0,0, 10'h0FF, 10'h080), // R8 clear, R6 keep, R4 keep
        mk(0,0,0,0,1,0, 10'h000, 10'h0C0), // R5 sets TC
        mk(1,0,1,0,0,0, 10'h000, 10'h040), // R7 read in same cycle does not count
        mk(0,0,1,0,0,0, 10'h000, 10'h000), // R7 marker still armed -> TC clears
        mk(0,0,0,1,0,0, 10'h000, 10'h080), // R4 reload
        mk(0,0,0,0,1,0, 10'h000, 10'h0C0), // R5 TC sets
        mk(0,0,1,0,0,0, 10'h000, 10'h040)  // R7 marker disarmed -> TC kept
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset status", stat_rdata, 32'h0000_00C0);
        check("R1", "reset irq", {31'b0, irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            {rd_stat, wr_stat, wr_data, evt_txe_load, evt_frame_done, evt_brk} = VEC[k][25:20];
            wdata = {22'b0, VEC[k][19:10]};
            @(negedge clk);
            check("R4-R8 table", $sformatf("vector %0d", k), {22'b0, stat_rdata[9:0]}, {22'b0, VEC[k][9:0]});
            {rd_stat, wr_stat, wr_data, evt_txe_load, evt_frame_done, evt_brk} = '0;
        end

        // R2: upper bits written with ones stay zero
        wr_stat = 1'b1; wdata = 32'hFFFF_FC40;
        @(negedge clk);
        wr_stat = 1'b0;
        check("R2", "upper bits", {10'b0, stat_rdata[31:10]}, 32'h0);
        check("R2", "whole word", stat_rdata, 32'h0000_0040);

        // R3: receive mirror, unaffected by status writes
        rx_flags = 6'h2D;
        #1;
        check("R3", "mirror", {26'b0, stat_rdata[5:0]}, 32'h2D);
        wr_stat = 1'b1; wdata = 32'h0;
        @(negedge clk);
        wr_stat = 1'b0;
        check("R3", "after write", stat_rdata, 32'h0000_002D);
        rx_flags = '0;

        // R9 / R10: clear-to-send change with detection on
        ie_cts = 1'b1; cts_flow_en = 1'b1;
        cts_n_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", "not yet after two edges", {31'b0, stat_rdata[9]}, 32'h0);
        @(negedge clk);
        check("R9", "set on third edge", {31'b0, stat_rdata[9]}, 32'h1);
        check("R10", "irq one cycle later", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10", "irq raised", {31'b0, irq}, 32'h1);
        wr_stat = 1'b1; wdata = 32'h0;
        @(negedge clk);
        wr_stat = 1'b0;
        check("R9", "zero write clears", {31'b0, stat_rdata[9]}, 32'h0);
        @(negedge clk);
        check("R10", "irq drops", {31'b0, irq}, 32'h0);

        // R9: detection off ignores changes
        cts_flow_en = 1'b0;
        cts_n_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9", "ignored when off", {31'b0, stat_rdata[9]}, 32'h0);

        // R10: transmit-empty interrupt
        ie_txe = 1'b1;
        evt_txe_load = 1'b1;
        @(negedge clk);
        evt_txe_load = 1'b0;
        check("R4", "txe set", {31'b0, stat_rdata[7]}, 32'h1);
        check("R10", "irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10", "irq from txe", {31'b0, irq}, 32'h1);

        finish_run();
    end
endmodule